// File: doc/BRIEF.md
# Multi-Channel Interval Timer

A register-mapped timer with a parameterised number of 32-bit down-counters (four by default). Software writes a reload value and sets the run bit. The counter then steps down once per clock from that value, and on the step after zero it raises a sticky timeout flag and reloads. A reload value of N therefore gives one timeout every N+1 counts. Each channel drives its own interrupt line, which is active while the flag is set and the channel's interrupt is enabled. A combined interrupt output is the OR of all the channel lines.

A channel can be linked to its lower neighbour. A linked channel takes one count step per timeout of that neighbour, which builds longer intervals out of two short counters. A single global stop bit freezes every counter at once. The register interface is a plain single-cycle bus: writes take effect at the clock edge and reads are combinational.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0 and all interrupt outputs are low.
- R2: Register map (byte addresses). Offset 0x000 is global control, with bit 1 as the global stop bit. Channel n occupies 0x100+0x10*n: the reload value at +0x0, the live count (read-only) at +0x4, control at +0x8 and the timeout flag at +0xC. In control, bit 0 is run, bit 1 is interrupt enable and bit 2 is link. Unmapped reads return 0.
- R3: A running, unlinked channel with reload value N reads N, N-1, …, 0, N, … in successive cycles, so it times out every N+1 clocks.
- R4: The step taken from count 0 reloads the reload value and sets bit 0 of the flag register. The flag then stays set until software clears it.
- R5: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.
- R6: A channel's interrupt output is high exactly while its flag is set and its interrupt-enable bit is 1. The combined output is the OR of all channel interrupts.
- R7: A linked channel n>0 steps once per timeout of channel n-1 and does not step on other clocks.
- R8: The link bit has no effect on channel 0, which still steps every clock.
- R9: While the global stop bit is set, no counter changes.
- R10: Writing control with run=0 holds the count. A write that changes run from 0 to 1 copies the reload value into the count.
- R11: Writing the reload value while the channel runs does not change the count. The new value is used at the next reload.
- R12: The channels count independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | NCH | Per-channel interrupt |
| irq_any_o | output | 1 | OR of all channel interrupts |

## Verification
Every channel is swept through reload values 0 to 4, and the count is checked each cycle against N minus the cycle index modulo N+1. This exposes off-by-one errors in the period and reload faults, and shows the live count on every step. The flag and interrupt lines are checked in the same sweep with interrupt enable both on and off, which separates the flag from its gating. Separate patterns cover a linked pair, where the expected count follows the floor of the cycle index over the lower channel's period. Further patterns cover two channels started one cycle apart, a global stop, reload writes during a run, and a stop followed by a restart. Each of these separates per-clock stepping from event stepping and from held state.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 12;
  localparam int unsigned CTL_W  = 3;

  typedef enum logic [1:0] {
    REG_LOAD = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTL  = 2'd2,
    REG_FLG  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic link;
    logic ie;
    logic run;
  } ctl_t;

  localparam int unsigned STOP_BIT = 1;
endpackage

// File: rtl/tick_decode.sv
module tick_decode
  import tick_timer_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  output logic           glb_hit_o,
  output logic           glb_wr_o,
  output logic           ch_hit_o,
  output logic [3:0]     ch_idx_o,
  output reg_sel_e       reg_sel_o,
  output logic [NCH-1:0] ld_wr_o,
  output logic [NCH-1:0] ctl_wr_o,
  output logic [NCH-1:0] flg_wr_o
);
  logic win;

  assign glb_hit_o = (addr_i == '0);
  assign glb_wr_o  = glb_hit_o & we_i;
  assign win       = (addr_i[11:8] == 4'h1) && (addr_i[1:0] == 2'b00);
  assign ch_idx_o  = addr_i[7:4];
  assign ch_hit_o  = win && (32'(ch_idx_o) < NCH);
  assign reg_sel_o = reg_sel_e'(addr_i[3:2]);

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    logic hit;
    assign hit         = ch_hit_o && we_i && (32'(ch_idx_o) == g);
    assign ld_wr_o[g]  = hit && (reg_sel_o == REG_LOAD);
    assign ctl_wr_o[g] = hit && (reg_sel_o == REG_CTL);
    assign flg_wr_o[g] = hit && (reg_sel_o == REG_FLG);
  end
endmodule

// File: rtl/tick_chan.sv
module tick_chan
  import tick_timer_pkg::*;
#(
  parameter bit HAS_PREV = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stop_i,
  input  logic          prev_to_i,
  input  logic          ld_wr_i,
  input  logic          ctl_wr_i,
  input  logic          flg_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cnt_o,
  output ctl_t          ctl_o,
  output logic          flag_o,
  output logic          to_o,
  output logic          irq_o
);
  logic [DW-1:0] load_q, cnt_q;
  ctl_t          ctl_q, ctl_d;
  logic          flag_q;
  logic          step, linked, start, clr;

  assign ctl_d  = ctl_t'(wdata_i[CTL_W-1:0]);
  assign linked = HAS_PREV && ctl_q.link;
  assign step   = ctl_q.run && !stop_i && (linked ? prev_to_i : 1'b1);
  assign to_o   = step && (cnt_q == '0);
  assign start  = ctl_wr_i && ctl_d.run && !ctl_q.run;
  assign clr    = flg_wr_i && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (ld_wr_i)  load_q <= wdata_i;
      if (ctl_wr_i) ctl_q  <= ctl_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start)   cnt_q <= load_q;
    else if (to_o)    cnt_q <= load_q;
    else if (step)    cnt_q <= cnt_q - 1'b1;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flag_q <= 1'b0;
    else if (to_o) flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctl_o  = ctl_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q && ctl_q.ie;

  // R4
  reload_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_o && !start && !ld_wr_i) |=> (cnt_q == $past(load_q)) && flag_q);
  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(flg_wr_i && wdata_i[0])) |=> flag_q);
  // R9
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !ctl_wr_i) |=> $stable(cnt_q));
  // R11
  load_no_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_wr_i && !step && !ctl_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [11:0]    addr_i,
  input  logic           we_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic [NCH-1:0] irq_o,
  output logic           irq_any_o
);
  logic           glb_hit, glb_wr, ch_hit, stop_q;
  logic [3:0]     ch_idx;
  reg_sel_e       reg_sel;
  logic [NCH-1:0] ld_wr, ctl_wr, flg_wr, to, flag;
  logic [DW-1:0]  load [NCH];
  logic [DW-1:0]  cnt  [NCH];
  ctl_t           ctl  [NCH];

  tick_decode #(.NCH(NCH)) u_dec (
    .addr_i, .we_i,
    .glb_hit_o(glb_hit), .glb_wr_o(glb_wr), .ch_hit_o(ch_hit),
    .ch_idx_o(ch_idx), .reg_sel_o(reg_sel),
    .ld_wr_o(ld_wr), .ctl_wr_o(ctl_wr), .flg_wr_o(flg_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stop_q <= 1'b0;
    else if (glb_wr) stop_q <= wdata_i[STOP_BIT];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic prev_to;
    if (g == 0) begin : g_head
      assign prev_to = 1'b0;
    end else begin : g_link
      assign prev_to = to[g-1];
    end
    tick_chan #(.HAS_PREV(g != 0)) u_ch (
      .clk_i, .rst_ni, .stop_i(stop_q), .prev_to_i(prev_to),
      .ld_wr_i(ld_wr[g]), .ctl_wr_i(ctl_wr[g]), .flg_wr_i(flg_wr[g]),
      .wdata_i, .load_o(load[g]), .cnt_o(cnt[g]), .ctl_o(ctl[g]),
      .flag_o(flag[g]), .to_o(to[g]), .irq_o(irq_o[g])
    );
  end

  assign irq_any_o = |irq_o;

  always_comb begin
    rdata_o = '0;
    if (glb_hit) rdata_o[STOP_BIT] = stop_q;
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit && 32'(ch_idx) == i) begin
        unique case (reg_sel)
          REG_LOAD: rdata_o = load[i];
          REG_CNT:  rdata_o = cnt[i];
          REG_CTL:  rdata_o = {{(DW-CTL_W){1'b0}}, ctl[i]};
          REG_FLG:  rdata_o = {{(DW-1){1'b0}}, flag[i]};
        endcase
      end
    end
  end

  // R7
  link_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl[1].run && ctl[1].link && !to[0] && !ctl_wr[1]) |=> $stable(cnt[1]));
  // R6
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> flag[0]);
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic we = 0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] irq;
  logic irq_any;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_timer #(.NCH(NCH)) u_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .irq_any_o(irq_any)
  );

  function automatic logic [11:0] ra(int ch, int r);
    return 12'(32'h100 + 16*ch + 4*r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  initial begin
    logic [31:0] v, v1, v2;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(12'h000, v); chk("R1", v, 0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++) begin rd(ra(c, r), v); chk("R1", v, 0); end
    chk("R1", {27'd0, irq_any, irq}, 0);
    // R2 readback, unmapped
    wr(ra(1, 0), 32'hA5A5_0F0F); rd(ra(1, 0), v); chk("R2", v, 32'hA5A5_0F0F);
    wr(ra(1, 2), 32'h6);         rd(ra(1, 2), v); chk("R2", v, 6);
    wr(ra(1, 2), 0);             rd(12'h104, v);  chk("R2", v, 0);
    rd(12'h140, v); chk("R2", v, 0);
    rd(12'h004, v); chk("R2", v, 0);
    wr(12'h000, 2); rd(12'h000, v); chk("R2", v, 2);
    wr(12'h000, 0);

    // R3 R4 R6 R8 R12: sweep channels and reload values
    for (int c = 0; c < NCH; c++)
      for (int n = 0; n <= 4; n++) begin
        logic ie;
        logic [31:0] cv;
        ie = n[0];
        cv = 32'(1) | (ie ? 32'h2 : 0) | ((c == 0 && n == 3) ? 32'h4 : 0);
        wr(ra(c, 0), n);
        wr(ra(c, 2), cv);
        for (int k = 0; k <= 3*(n+1); k++) begin
          if (k > 0) @(negedge clk);
          rd(ra(c, 1), v);
          chk((c == 0 && n == 3) ? "R8" : "R3", v, 32'(n - (k % (n+1))));
          rd(ra(c, 3), v);
          chk("R4", v, (k >= n+1) ? 1 : 0);
          chk("R6", {31'd0, irq[c]}, (ie && k >= n+1) ? 1 : 0);
          chk("R6", {31'd0, irq_any}, (ie && k >= n+1) ? 1 : 0);
        end
        wr(ra(c, 2), 0);
        wr(ra(c, 3), 0);
        rd(ra(c, 3), v); chk("R5", v, 1);
        wr(ra(c, 3), 1);
        rd(ra(c, 3), v); chk("R5", v, 0);
      end

    // R7 linked pair: ch0 N=2, ch1 N=1 linked
    wr(ra(0, 0), 2); wr(ra(1, 0), 1);
    wr(ra(1, 2), 5);
    wr(ra(0, 2), 1);
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      rd(ra(1, 1), v);
      chk("R7", v, 32'(1 - ((k/3) % 2)));
    end
    wr(ra(0, 2), 0); wr(ra(1, 2), 0);
    wr(ra(0, 3), 1); wr(ra(1, 3), 1);

    // R12 two channels started a cycle apart
    wr(ra(2, 0), 3); wr(ra(3, 0), 4);
    wr(ra(2, 2), 1); wr(ra(3, 2), 1);
    for (int k = 0; k < 25; k++) begin
      if (k > 0) @(negedge clk);
      addr = ra(2, 1); #1 v1 = rdata;
      addr = ra(3, 1); #1 v2 = rdata;
      chk("R12", v1, 32'(3 - ((k+1) % 4)));
      chk("R12", v2, 32'(4 - (k % 5)));
    end

    // R9 global stop
    wr(ra(2, 0), 50); wr(ra(2, 2), 0); wr(ra(2, 2), 1);
    repeat (3) @(negedge clk);
    wr(12'h000, 2);
    rd(ra(2, 1), v1);
    repeat (5) @(negedge clk);
    rd(ra(2, 1), v); chk("R9", v, v1);
    rd(ra(3, 1), v2);
    repeat (2) @(negedge clk);
    rd(ra(3, 1), v); chk("R9", v, v2);
    wr(12'h000, 0);
    rd(ra(2, 1), v); chk("R9", v, v1);
    @(negedge clk);
    rd(ra(2, 1), v); chk("R9", v, v1 - 1);

    // R10 stop and restart
    wr(ra(2, 2), 0);
    rd(ra(2, 1), v1);
    repeat (4) @(negedge clk);
    rd(ra(2, 1), v); chk("R10", v, v1);
    wr(ra(2, 0), 7);
    rd(ra(2, 1), v); chk("R10", v, v1);
    wr(ra(2, 2), 1);
    rd(ra(2, 1), v); chk("R10", v, 7);
    @(negedge clk);
    rd(ra(2, 1), v); chk("R10", v, 6);

    // R11 reload write while running
    wr(ra(3, 2), 0); wr(ra(3, 0), 8); wr(ra(3, 2), 1);
    rd(ra(3, 1), v1);
    wr(ra(3, 0), 100);
    rd(ra(3, 1), v2); chk("R11", v2, v1 - 1);
    repeat (int'(v2) + 1) @(negedge clk);
    rd(ra(3, 1), v); chk("R11", v, 100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule